// File: doc/BRIEF.md
# Camera Frame Cropper with Ping-Pong Bank Addressing

This block sits behind the camera-side synchronizer. It takes a stream of pixels already in the system clock domain and follows each pixel's line and column position inside the incoming 356 by 292 frame. Only pixels inside a 256 by 256 window are kept. For each kept pixel it pushes the pixel byte and a write address into a FIFO that feeds the frame memory.

The frame memory holds two frame buffers. The block writes each new frame into one buffer while the other buffer, which holds the last finished frame, is shown on the display. A frame-start pulse from the camera clears the position counters and swaps the buffers. The display side learns which buffer is complete from an output of this block. The window offsets default to a centred window: 50 columns in and 18 lines down.

Top module: `frame_crop_writer`

## Requirements
- R1: After reset, `fifoPush`, `fillBank`, `showBank`, `showValid` and `overflow` are all 0.
- R2: Each cycle with `pixValid` high advances the column position by one. After column FRAME_W-1 the column returns to 0 and the line advances by one.
- R3: A pixel is kept only if its column is in [COL_OFF, COL_OFF+WIN_W) and its line is in [ROW_OFF, ROW_OFF+WIN_H). A kept pixel raises `fifoPush` for one cycle, on the clock edge that follows the cycle in which it was presented.
- R4: `fifoData` carries the kept pixel byte. `fifoAddr` is {bank bit, line-ROW_OFF, column-COL_OFF}. The bank bit is the MSB, and the column occupies the low log2(WIN_W) bits. With the default parameters this address is 17 bits wide.
- R5: `frameStart` resets the line and column positions to 0. A pixel presented in the same cycle as `frameStart` is discarded and does not count as a position.
- R6: Pixels are discarded, and cause no push, in two cases: before the first `frameStart` after reset, and once FRAME_H lines have been received, until the next `frameStart`.
- R7: The first `frameStart` after reset does not change any bank output. Every later `frameStart` does three things one cycle later: it inverts `fillBank`, it loads `showBank` with the previous `fillBank`, and it sets `showValid` to 1.
- R8: If `fifoFull` is high while a pixel that would be kept is presented, there is no push and `overflow` goes to 1 on the next edge. `overflow` then stays 1 until reset. Pixel positions still advance.
- R9: A cycle with `pixValid` low and no `frameStart` changes no position and produces no push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Pixel strobe, one pixel per high cycle |
| pixData | input | DATA_W | Pixel byte |
| frameStart | input | 1 | Start-of-frame pulse from the camera |
| fifoFull | input | 1 | Write FIFO cannot accept a word |
| fifoPush | output | 1 | Write strobe into the FIFO |
| fifoData | output | DATA_W | Pixel byte for the FIFO |
| fifoAddr | output | ADDR_W | Frame memory address {bank, line, column} |
| fillBank | output | 1 | Buffer currently being filled |
| showBank | output | 1 | Buffer holding the last completed frame |
| showValid | output | 1 | A completed frame exists in `showBank` |
| overflow | output | 1 | Sticky flag: a kept pixel was lost to a full FIFO |

## Verification
A column counter that is off by one shifts the whole image. This shows up at the window edges: a push appears on a column just outside the window, or the low bits of `fifoAddr` differ from the expected value, on the very next push. A line counter error shows the same way, but only after a whole camera line, at the top or bottom window row. A bank register out of step shows in the MSB of the address of the first push of the next frame, and in `showBank` one cycle after `frameStart`. The bench therefore probes every window edge, a full frame sweep with idle gaps, the extra lines that arrive after the last counted line, and the bank sequence across many frames.

// File: rtl/fcw_pkg.sv
package fcw_pkg;
  // Per-pixel decisions handed from the control to the datapath
  typedef struct packed {
    logic take;  // pixel is inside the window and the FIFO has room
    logic lost;  // pixel is inside the window but the FIFO is full
  } fcwStrobeT;
endpackage

// File: rtl/fcw_ctrl.sv
module fcw_ctrl
  import fcw_pkg::*;
#(
  parameter int FRAME_W = 356,
  parameter int FRAME_H = 292,
  parameter int WIN_W   = 256,
  parameter int WIN_H   = 256,
  parameter int COL_OFF = 50,
  parameter int ROW_OFF = 18,
  localparam int COL_W  = $clog2(FRAME_W),
  localparam int ROW_W  = $clog2(FRAME_H)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic             frameStart,
  input  logic             fifoFull,
  output logic [COL_W-1:0] colCnt,
  output logic [ROW_W-1:0] rowCnt,
  output logic             fillBank,
  output logic             showBank,
  output logic             showValid,
  output fcwStrobeT        strobe
);
  localparam int COL_END = COL_OFF + WIN_W;
  localparam int ROW_END = ROW_OFF + WIN_H;

  logic active;   // lines remain in the current frame
  logic started;  // a frame start has been seen since reset
  logic lastCol;
  logic lastRow;
  logic inWin;
  logic pixLive;

  assign lastCol = (colCnt == COL_W'(FRAME_W - 1));
  assign lastRow = (rowCnt == ROW_W'(FRAME_H - 1));
  assign inWin   = (32'(colCnt) >= COL_OFF) && (32'(colCnt) < COL_END) &&
                   (32'(rowCnt) >= ROW_OFF) && (32'(rowCnt) < ROW_END);
  assign pixLive = pixValid && active && !frameStart;

  always_comb begin
    strobe.take = pixLive && inWin && !fifoFull;
    strobe.lost = pixLive && inWin && fifoFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt    <= '0;
      rowCnt    <= '0;
      active    <= 1'b0;
      started   <= 1'b0;
      fillBank  <= 1'b0;
      showBank  <= 1'b0;
      showValid <= 1'b0;
    end else if (frameStart) begin
      colCnt  <= '0;
      rowCnt  <= '0;
      active  <= 1'b1;
      started <= 1'b1;
      if (started) begin
        showBank  <= fillBank;
        fillBank  <= ~fillBank;
        showValid <= 1'b1;
      end
    end else if (pixValid && active) begin
      if (lastCol) begin
        colCnt <= '0;
        if (lastRow) active <= 1'b0;
        else         rowCnt <= rowCnt + 1'b1;
      end else begin
        colCnt <= colCnt + 1'b1;
      end
    end
  end

  a_r2_col_bound: assert property (@(posedge clk) disable iff (!rstN)
    32'(colCnt) < FRAME_W);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!pixValid && !frameStart) |=> ($stable(colCnt) && $stable(rowCnt)));

  a_r7_bank_swap: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && started) |=> (fillBank != $past(fillBank)) &&
                                (showBank == $past(fillBank)) && showValid);

  a_r5_restart: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (colCnt == '0) && (rowCnt == '0));
endmodule

// File: rtl/fcw_dpath.sv
module fcw_dpath
  import fcw_pkg::*;
#(
  parameter int FRAME_W = 356,
  parameter int FRAME_H = 292,
  parameter int WIN_W   = 256,
  parameter int WIN_H   = 256,
  parameter int COL_OFF = 50,
  parameter int ROW_OFF = 18,
  parameter int DATA_W  = 8,
  localparam int COL_W  = $clog2(FRAME_W),
  localparam int ROW_W  = $clog2(FRAME_H),
  localparam int WCOL_W = $clog2(WIN_W),
  localparam int WROW_W = $clog2(WIN_H),
  localparam int ADDR_W = 1 + WROW_W + WCOL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fcwStrobeT         strobe,
  input  logic [COL_W-1:0]  colCnt,
  input  logic [ROW_W-1:0]  rowCnt,
  input  logic              fillBank,
  input  logic [DATA_W-1:0] pixData,
  output logic              fifoPush,
  output logic [DATA_W-1:0] fifoData,
  output logic [ADDR_W-1:0] fifoAddr,
  output logic              overflow
);
  logic [COL_W-1:0]  colRel;
  logic [ROW_W-1:0]  rowRel;
  logic [ADDR_W-1:0] nextAddr;

  assign colRel   = colCnt - COL_W'(COL_OFF);
  assign rowRel   = rowCnt - ROW_W'(ROW_OFF);
  assign nextAddr = {fillBank, rowRel[WROW_W-1:0], colRel[WCOL_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoPush <= 1'b0;
      fifoData <= '0;
      fifoAddr <= '0;
      overflow <= 1'b0;
    end else begin
      fifoPush <= strobe.take;
      if (strobe.take) begin
        fifoData <= pixData;
        fifoAddr <= nextAddr;
      end
      if (strobe.lost) overflow <= 1'b1;
    end
  end

  a_r3_push_follows_take: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> fifoPush);

  a_r3_no_spurious_push: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> !fifoPush);

  a_r8_full_drops: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lost |=> (!fifoPush && overflow));

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> $stable(fifoAddr));
endmodule

// File: rtl/frame_crop_writer.sv
module frame_crop_writer
  import fcw_pkg::*;
#(
  parameter int FRAME_W = 356,
  parameter int FRAME_H = 292,
  parameter int WIN_W   = 256,
  parameter int WIN_H   = 256,
  parameter int COL_OFF = 50,
  parameter int ROW_OFF = 18,
  parameter int DATA_W  = 8,
  localparam int COL_W  = $clog2(FRAME_W),
  localparam int ROW_W  = $clog2(FRAME_H),
  localparam int ADDR_W = 1 + $clog2(WIN_H) + $clog2(WIN_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic [DATA_W-1:0] pixData,
  input  logic              frameStart,
  input  logic              fifoFull,
  output logic              fifoPush,
  output logic [DATA_W-1:0] fifoData,
  output logic [ADDR_W-1:0] fifoAddr,
  output logic              fillBank,
  output logic              showBank,
  output logic              showValid,
  output logic              overflow
);
  logic [COL_W-1:0] colCnt;
  logic [ROW_W-1:0] rowCnt;
  fcwStrobeT        strobe;

  fcw_ctrl #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .WIN_W(WIN_W), .WIN_H(WIN_H),
    .COL_OFF(COL_OFF), .ROW_OFF(ROW_OFF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .frameStart(frameStart),
    .fifoFull(fifoFull), .colCnt(colCnt), .rowCnt(rowCnt),
    .fillBank(fillBank), .showBank(showBank), .showValid(showValid),
    .strobe(strobe)
  );

  fcw_dpath #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .WIN_W(WIN_W), .WIN_H(WIN_H),
    .COL_OFF(COL_OFF), .ROW_OFF(ROW_OFF), .DATA_W(DATA_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .colCnt(colCnt),
    .rowCnt(rowCnt), .fillBank(fillBank), .pixData(pixData),
    .fifoPush(fifoPush), .fifoData(fifoData), .fifoAddr(fifoAddr),
    .overflow(overflow)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!fifoPush && !overflow && !showValid && !fillBank));
endmodule

// File: tb/frame_crop_writer_bench.sv
module frame_crop_writer_bench;
  localparam int FW = 12, FH = 10, WW = 8, WH = 4, CO = 2, RO = 3;
  localparam int AW = 1 + 2 + 3;
  localparam int NV = 9;
  // probe vectors: column, line, expected kept
  localparam int vCol [NV] = '{2, 1, 9, 10, 2, 2, 5, 11, 0};
  localparam int vRow [NV] = '{3, 3, 3, 3, 2, 6, 7, 5, 4};
  localparam bit vKeep[NV] = '{1, 0, 1, 0, 0, 1, 0, 0, 0};

  logic clk = 0, rstN = 0, pixValid = 0, frameStart = 0, fifoFull = 0;
  logic [7:0] pixData = 0;
  logic fifoPush, fillBank, showBank, showValid, overflow;
  logic [7:0] fifoData;
  logic [AW-1:0] fifoAddr;
  int checks = 0, errors = 0;
  bit started = 0, expBank = 0, done = 0;

  always #10 clk = ~clk;

  frame_crop_writer #(.FRAME_W(FW), .FRAME_H(FH), .WIN_W(WW), .WIN_H(WH),
    .COL_OFF(CO), .ROW_OFF(RO), .DATA_W(8)) u_frame_crop_writer (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixData(pixData),
    .frameStart(frameStart), .fifoFull(fifoFull), .fifoPush(fifoPush),
    .fifoData(fifoData), .fifoAddr(fifoAddr), .fillBank(fillBank),
    .showBank(showBank), .showValid(showValid), .overflow(overflow));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ea(input bit b, input int c, input int r);
    return b * 32 + (r - RO) * 8 + (c - CO);
  endfunction

  function automatic logic [7:0] pd(input int c, input int r);
    return 8'((r * FW + c) * 7 + 3);
  endfunction

  // present one cycle of inputs, return after the following edge (at negedge)
  task automatic step(input bit v, input bit fs, input bit full, input logic [7:0] d);
    pixValid = v; frameStart = fs; fifoFull = full; pixData = d;
    @(negedge clk);
    pixValid = 0; frameStart = 0; fifoFull = 0;
  endtask

  task automatic newFrame();
    step(0, 1, 0, 0);
    if (started) expBank = ~expBank;
    started = 1;
  endtask

  task automatic runTo(input int tc, input int tr, input bit fullLast);
    for (int r = 0; r <= tr; r++)
      for (int c = 0; c < FW; c++) begin
        if (r == tr && c > tc) break;
        step(1, 0, (r == tr && c == tc) ? fullLast : 1'b0, pd(c, r));
      end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk(!fifoPush && !fillBank && !showBank && !showValid && !overflow, "R1",
        {fifoPush, fillBank, showBank, showValid, overflow}, 0);
    // R6 pixels before any frame start are discarded
    for (int i = 0; i < 40; i++) begin
      step(1, 0, 0, 8'(i));
      if (fifoPush) chk(0, "R6 pre-start push", 1, 0);
    end
    chk(!fifoPush, "R6 pre-start", fifoPush, 0);
    // R7 first frame start leaves banks
    newFrame();
    chk(!fillBank && !showValid && !showBank, "R7 first start",
        {fillBank, showBank, showValid}, 0);
    // R2 R3 R4 R9 full frame sweep with idle gaps
    for (int r = 0; r < FH; r++)
      for (int c = 0; c < FW; c++) begin
        bit k;
        if (c == 4) begin
          step(0, 0, 0, 8'hAA);
          chk(!fifoPush, "R9 idle no push", fifoPush, 0);
        end
        step(1, 0, 0, pd(c, r));
        k = (c >= CO && c < CO + WW && r >= RO && r < RO + WH);
        chk(fifoPush == k, "R3 window", fifoPush, k);
        if (k) begin
          chk(int'(fifoAddr) == ea(expBank, c, r), "R4 addr", fifoAddr, ea(expBank, c, r));
          chk(fifoData == pd(c, r), "R4 data", fifoData, pd(c, r));
        end
      end
    // R6 lines beyond the frame are discarded
    for (int i = 0; i < 2 * FW; i++) begin
      step(1, 0, 0, 8'(i));
      if (fifoPush) chk(0, "R6 overrun push", 1, 0);
    end
    chk(!fifoPush, "R6 overrun", fifoPush, 0);
    // R7 second start swaps
    newFrame();
    chk(fillBank == 1 && showBank == 0 && showValid, "R7 swap",
        {fillBank, showBank, showValid}, 3'b101);
    // table walk of window edges, one frame per probe
    for (int i = 0; i < NV; i++) begin
      newFrame();
      chk(fillBank == expBank && showBank == !expBank, "R7 bank seq", fillBank, expBank);
      runTo(vCol[i], vRow[i], 0);
      chk(fifoPush == vKeep[i], "R3 edge probe", fifoPush, vKeep[i]);
      if (vKeep[i])
        chk(int'(fifoAddr) == ea(expBank, vCol[i], vRow[i]), "R4 edge addr",
            fifoAddr, ea(expBank, vCol[i], vRow[i]));
    end
    // R5 pixel in the same cycle as the frame start is discarded
    step(1, 1, 0, 8'h55);
    expBank = ~expBank;
    runTo(CO, RO, 0);
    chk(fifoPush && int'(fifoAddr) == ea(expBank, CO, RO), "R5 same-cycle pixel",
        fifoAddr, ea(expBank, CO, RO));
    // R5 restart mid-frame clears the position
    newFrame();
    runTo(CO + 1, RO, 0);
    chk(int'(fifoAddr) == ea(expBank, CO + 1, RO), "R5 restart", fifoAddr, ea(expBank, CO + 1, RO));
    // R8 full FIFO drops a kept pixel, sets sticky flag
    newFrame();
    chk(!overflow, "R8 clear before", overflow, 0);
    runTo(CO, RO, 1);
    chk(!fifoPush, "R8 no push when full", fifoPush, 0);
    chk(overflow, "R8 flag set", overflow, 1);
    step(1, 0, 0, pd(CO + 1, RO));
    chk(fifoPush && int'(fifoAddr) == ea(expBank, CO + 1, RO), "R8 position kept",
        fifoAddr, ea(expBank, CO + 1, RO));
    chk(overflow, "R8 sticky", overflow, 1);
    newFrame();
    chk(overflow, "R8 sticky across frame", overflow, 1);
    // R1 reset clears everything again
    rstN = 0; @(negedge clk); rstN = 1;
    chk(!overflow && !fillBank && !showValid && !fifoPush, "R1 re-reset",
        {overflow, fillBank, showValid, fifoPush}, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule